// File: doc/BRIEF.md
# Four-Entry Page-Directory-Pointer Loader and Checker

This block fetches the four 64-bit page-directory-pointer entries that 32-bit extended-address paging depends on, keeps a copy of them, and decides whether they are usable. A start pulse carries a table-base value. The block clears the five low bits of that base, so the table sits on a 32-byte boundary. It then reads the entries one by one through a simple physical-memory read port and stores each returned word in its own cache slot.

Every returned word is checked as it arrives. A word whose present bit (bit 0) is clear is accepted whatever its other bits hold. A word whose present bit is set is rejected if any bit of a parameterised reserved mask is also set. The first rejected word ends the sequence at once. The block then pulses done with a failing result and drops the cache-valid flag. If all four words are accepted, the block pulses done with a passing result and raises cache-valid. A page walker reads the stored words through a registered slot-select port.

Top module: `pdpt_fetch_check`

## Requirements
- R1: Every read address is built from the start base with bits 4:0 forced to zero.
- R2: Reads go out in slot order 0, 1, 2, 3 at masked base OR (n << 3). Each request is a one-cycle pulse, and the next one is issued only after the previous data has returned.
- R3: The data returned for slot n is stored in slot n. Driving rd_sel_i with n puts that slot on rd_data_o one clock later.
- R4: A word with bit 0 clear is accepted whatever its other bits hold.
- R5: A word with bit 0 set is rejected if any reserved bit is set. With the default parameters the reserved bits are 1, 2, 5 to 8, and 36 to 63. Bits 3, 4 and 9 to 35 are allowed.
- R6: On the first rejected word the block issues no further reads and pulses done_o with ok_o low, and cache_valid_o goes low. Slots already loaded keep their data.
- R7: When all four words are accepted, done_o pulses with ok_o high and cache_valid_o goes high.
- R8: done_o is high for exactly one cycle per finished sequence. ok_o holds the last result until the next one.
- R9: A start pulse that arrives while a sequence is running has no effect.
- R10: Synchronous reset returns the block to idle with cache_valid_o, done_o and mem_req_o low. Any read data that arrives after reset is ignored.
- R11: Accepting a start pulse clears cache_valid_o on the next cycle, before the first word returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load-and-check sequence |
| base_i | input | 32 | Table base value; low five bits are ignored |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the requested 64-bit word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Returned 64-bit entry |
| done_o | output | 1 | One-cycle pulse when a sequence finishes |
| ok_o | output | 1 | Result of the last sequence (1 = all entries usable) |
| cache_valid_o | output | 1 | Cached entries are loaded and usable |
| rd_sel_i | input | 2 | Cache slot to read |
| rd_data_o | output | 64 | Registered contents of the selected slot |

## Verification
The assertions assume that memory returns exactly one rvalid for each request and never sends rvalid when no read is outstanding. Under those conditions the slot index that is in flight always matches the request that is waiting. The bench memory model meets this assumption: it latches one pending request, answers it after a programmable delay, and drops the pending request on reset, so no stray response reaches the block. Stimulus runs the table of entry patterns at several response delays. It then adds a start pulse in the middle of a sequence, a reset in the middle of a sequence, and a restart from the valid state.

// File: rtl/pdpt_pkg.sv
package pdpt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } pdpt_state_e;

  // Reserved bits of a present entry: 1, 2, 5..8 and everything at or above pa_w
  function automatic logic [63:0] rsvd_default(input int pa_w);
    logic [63:0] m;
    m = '0;
    m[1] = 1'b1;
    m[2] = 1'b1;
    for (int b = 5; b <= 8; b++) m[b] = 1'b1;
    for (int b = 0; b < 64; b++) if (b >= pa_w) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pdpt_entry_check.sv
module pdpt_entry_check #(
  parameter int          DATA_W    = 64,
  parameter logic [DATA_W-1:0] RSVD_MASK = '0
) (
  input  logic [DATA_W-1:0] entry_i,
  output logic              bad_o
);
  logic present;
  logic rsvd_hit;

  always_comb begin
    present  = entry_i[0];
    rsvd_hit = |(entry_i & RSVD_MASK);
    bad_o    = present & rsvd_hit;
  end
endmodule

// File: rtl/pdpt_cache.sv
module pdpt_cache #(
  parameter int DATA_W = 64,
  parameter int N_ENT  = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rsel_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we_i && (widx_i == IDX_W'(g))) slot_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    rdata_o <= slot_q[rsel_i];
  end
endmodule

// File: rtl/pdpt_fetch_check.sv
module pdpt_fetch_check #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int N_ENT   = 4,
  parameter int PA_W    = 36,
  parameter int ALIGN_B = 5,
  parameter logic [DATA_W-1:0] RSVD_MASK = pdpt_pkg::rsvd_default(PA_W),
  localparam int IDX_W    = $clog2(N_ENT),
  localparam int STRIDE_B = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              ok_o,
  output logic              cache_valid_o,
  input  logic [IDX_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import pdpt_pkg::*;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_B) - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(N_ENT - 1);
  localparam int                PAD_W      = ADDR_W - IDX_W - STRIDE_B;

  pdpt_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  nidx;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] masked_base;
  logic              entry_bad;
  logic              take;

  always_comb begin
    masked_base = base_i & ALIGN_MASK;
    nidx        = idx_q + IDX_W'(1);
    take        = (state_q == ST_WAIT) && mem_rvalid_i;
  end

  pdpt_entry_check #(
    .DATA_W   (DATA_W),
    .RSVD_MASK(RSVD_MASK)
  ) u_check (
    .entry_i(mem_rdata_i),
    .bad_o  (entry_bad)
  );

  pdpt_cache #(
    .DATA_W(DATA_W),
    .N_ENT (N_ENT)
  ) u_cache (
    .clk    (clk),
    .we_i   (take),
    .widx_i (idx_q),
    .wdata_i(mem_rdata_i),
    .rsel_i (rd_sel_i),
    .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      base_q        <= '0;
      mem_req_o     <= 1'b0;
      mem_addr_o    <= '0;
      done_o        <= 1'b0;
      ok_o          <= 1'b0;
      cache_valid_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      mem_req_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q        <= masked_base;
            idx_q         <= '0;
            mem_req_o     <= 1'b1;
            mem_addr_o    <= masked_base;
            cache_valid_o <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (entry_bad || (idx_q == LAST_IDX)) begin
              done_o        <= 1'b1;
              ok_o          <= ~entry_bad;
              cache_valid_o <= ~entry_bad;
              state_q       <= ST_IDLE;
            end else begin
              idx_q      <= nidx;
              mem_req_o  <= 1'b1;
              mem_addr_o <= base_q | {{PAD_W{1'b0}}, nidx, {STRIDE_B{1'b0}}};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[STRIDE_B-1:0] == '0)); // R1
  AST_ADDR_SLOT: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[STRIDE_B +: IDX_W] == idx_q)); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ok_o) |-> !cache_valid_o); // R6
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_req_o); // R6
  AST_PASS_SETS: assert property (@(posedge clk) disable iff (rst)
    (done_o && ok_o) |-> (cache_valid_o && idx_q == LAST_IDX)); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i) |=> (!cache_valid_o && mem_req_o)); // R11
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !mem_rvalid_i) |=> $stable(base_q)); // R9
endmodule

// File: tb/pdpt_fetch_check_bench.sv
`timescale 1ns/1ps
module pdpt_fetch_check_bench;

  typedef struct packed {
    logic [31:0] base;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [63:0] e3;
    logic        ok;
    logic [2:0]  nrd;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // all present, clean, bits 32..35 allowed (R7, R1 low-bit masking)
    '{32'h0012_345F, 64'h0000_0001_2345_6001, 64'h0000_000F_FFFF_F001,
      64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 3'd4, 3'd0},
    // slot 1 present with bit 1 -> fail after two reads (R5, R6)
    '{32'h0000_8004, 64'h0000_0000_0000_1001, 64'h0000_0000_0000_0003,
      64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0, 3'd2, 3'd2},
    // not present, all other bits set -> pass (R4)
    '{32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE,
      64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 3'd4, 3'd1},
    // slot 3 present with bit 36 -> fail on last read (R5 width boundary)
    '{32'h0100_0020, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001,
      64'h0000_0000_0000_0001, 64'h0000_0010_0000_0001, 1'b0, 3'd4, 3'd3},
    // slot 0 present with bit 8 -> fail after one read (R5, R6)
    '{32'h0000_1000, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0001,
      64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0, 3'd1, 3'd0},
    // slot 2 present with bit 63 -> fail after three reads (R5)
    '{32'h0000_2010, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000,
      64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0, 3'd3, 3'd4},
    // present with bits 3, 4, 9..35 -> pass (R5 allowed bits)
    '{32'h0000_3000, 64'h0000_000F_FFFF_FE19, 64'h0000_000F_FFFF_FE19,
      64'h0000_0000_0000_0019, 64'h0000_0008_0000_0201, 1'b1, 3'd4, 3'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [63:0] mem_rdata_i;
  logic        done_o;
  logic        ok_o;
  logic        cache_valid_o;
  logic [1:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pdpt_fetch_check u_pdpt_fetch_check (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .base_i       (base_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .ok_o         (ok_o),
    .cache_valid_o(cache_valid_o),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o)
  );

  // memory model: one pending read, fixed latency, cleared on reset
  logic [63:0] mem [4];
  logic [2:0]  lat = '0;
  logic        clr_log = 1'b0;
  logic        pend = 1'b0;
  logic [2:0]  tmr = '0;
  logic [31:0] paddr = '0;
  logic [31:0] alog [8];
  int          nreq = 0;

  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
  end

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (pend) begin
      if (tmr == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[paddr[4:3]];
        pend <= 1'b0;
      end else begin
        tmr <= tmr - 3'd1;
      end
    end
    if (clr_log) begin
      nreq <= 0;
    end else if (mem_req_o && !rst) begin
      pend  <= 1'b1;
      tmr   <= lat;
      paddr <= mem_addr_o;
      if (nreq < 8) alog[nreq] <= mem_addr_o;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(input vec_t v, input int k);
    case (k)
      0: return v.e0;
      1: return v.e1;
      2: return v.e2;
      default: return v.e3;
    endcase
  endfunction

  task automatic clear_log();
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (n < 200) begin
      @(negedge clk);
      if (done_o) begin
        seen = 1'b1;
        break;
      end
      n++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit seen;
    for (int k = 0; k < 4; k++) mem[k] = ent(v, k);
    lat = v.lat;
    clear_log();
    @(negedge clk);
    start_i = 1'b1;
    base_i  = v.base;
    @(negedge clk);
    start_i = 1'b0;
    if (done_o) seen = 1'b1; else wait_done(seen);
    chk("R8 done seen", 64'(seen), 64'd1);
    chk("R6/R7 ok_o", 64'(ok_o), 64'(v.ok));
    chk("R6/R7 cache_valid_o", 64'(cache_valid_o), 64'(v.ok));
    @(negedge clk);
    chk("R8 done one cycle", 64'(done_o), 64'd0);
    chk("R8 ok_o held", 64'(ok_o), 64'(v.ok));
    repeat (12) @(negedge clk);
    chk("R2/R6 read count", 64'(nreq), 64'(v.nrd));
    for (int k = 0; k < int'(v.nrd); k++)
      chk("R1/R2 read address", 64'(alog[k]), 64'((v.base & 32'hFFFF_FFE0) | (k << 3)));
    for (int k = 0; k < int'(v.nrd); k++) begin
      rd_sel_i = 2'(k);
      @(negedge clk);
      chk("R3 slot contents", rd_data_o, ent(v, k));
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit seen;
    for (int k = 0; k < 4; k++) mem[k] = '0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", 64'(cache_valid_o), 64'd0);
    chk("R10 reset done", 64'(done_o), 64'd0);
    chk("R10 reset req", 64'(mem_req_o), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: restart from valid state clears valid before data returns
    run_vec(VECS[0]);
    lat = 3'd3;
    @(negedge clk);
    start_i = 1'b1;
    base_i  = VECS[0].base;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 valid cleared on start", 64'(cache_valid_o), 64'd0);
    wait_done(seen);
    chk("R11 restart completes", 64'(ok_o), 64'd1);

    // R9: start during a running sequence has no effect
    for (int k = 0; k < 4; k++) mem[k] = 64'h1;
    lat = 3'd5;
    clear_log();
    @(negedge clk);
    start_i = 1'b1;
    base_i  = 32'h0000_5000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    base_i  = 32'h0000_9000;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(seen);
    repeat (30) @(negedge clk);
    chk("R9 read count", 64'(nreq), 64'd4);
    for (int k = 0; k < 4; k++)
      chk("R9 address from first base", 64'(alog[k]), 64'(32'h0000_5000 | (k << 3)));

    // R10: reset in the middle of a sequence
    clear_log();
    @(negedge clk);
    start_i = 1'b1;
    base_i  = 32'h0000_6000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset valid", 64'(cache_valid_o), 64'd0);
    chk("R10 mid reset req", 64'(mem_req_o), 64'd0);
    rst = 1'b0;
    clear_log();
    repeat (30) @(negedge clk);
    chk("R10 no reads after reset", 64'(nreq), 64'd0);
    chk("R10 no done after reset", 64'(done_o), 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule